// File: doc/BRIEF.md
# Front-End Board Slow-Control Bridge

This block connects a register-style host bus to a front-end board that powers and monitors two pixel sensors. The host writes one control word. It holds the enable and discharge bits of the four switchable supplies: an analog supply and a digital supply for each sensor. It also holds four signal-switch bits. A discharge bit shorts its supply output so that downstream decoupling capacitors are drained. Each sensor has two signal-switch bits. One passes that sensor's clock, reset and start lines. The other puts the sensor into the JTAG chain when it is 1 and bypasses the sensor when it is 0. Every change to the control word is forwarded to the board microcontroller as two short commands on a UART transmitter.

In the other direction, the board streams all 32 monitoring readings over SPI. Each reading is a 16-bit ADC value. The block collects each complete stream and copies it into a readable mirror, so the host always sees one consistent set of readings.

Each supply has an overcurrent indicator input. The block synchronizes these inputs into sticky flags. A set flag forces the enable of its supply low until the host clears the flag. A new overcurrent event also sends a fresh power command to the board.

Top module: `feb_bridge`

## Requirements
- R1: A write to address 0 stores the 12-bit control word, which the outputs show from the next clock edge.
  - Bits [3:0] are the supply enables, in the order sensor0 analog, sensor0 digital, sensor1 analog, sensor1 digital.
  - Bits [7:4] are the discharge bits, in the same supply order.
  - Bits [11:8] are the switches: sensor0 line enable, sensor0 JTAG enable, sensor1 line enable, sensor1 JTAG enable.
  - A read of address 0 returns the written word.
- R2: `pwr_en_o[i]` equals the stored enable bit i ANDed with the inverse of overcurrent flag i. Discharge and switch outputs are never masked.
- R3: `oc_i` passes through a two-stage synchronizer. A high level sets the matching flag on the third rising edge after it is applied. The flags read back on bits [3:0] of address 1.
- R4: Writing a 1 to a bit of address 1 clears that flag. Writing a 0 leaves the flag unchanged. A synchronized overcurrent level wins over a clear in the same cycle.
- R5: Every control write sends four UART bytes: 0x01, then {discharge[3:0], effective enables[3:0]}, then 0x02, then {4'b0, switches[3:0]}. A flag that newly sets sends the same four bytes, built with the masked enables.
- R6: The UART is 8N1, least significant bit first, with `CLKS_PER_BIT` clocks per bit. The line idles high.
- R7: SPI is mode 0, most significant bit first, and a low `spi_cs_ni` frames a transfer. A frame of exactly 32 complete 16-bit words updates all readings when chip select rises.
- R8: A frame with fewer than 32 words, or with leftover bits after its last word, is discarded. The previous readings stay readable unchanged.
- R9: Reads of unmapped addresses (2 to 15 and 48 to 63) return zero. Writes to unmapped addresses change nothing.
- R10: Reading k of a frame is readable at address 16+k.
  - Sensor 0 fills words 0 to 15 and sensor 1 fills words 16 to 31.
  - Within each sensor the words come in this order: digital current, analog current, digital voltage, analog voltage, ground drop, temperature diode, four discriminator baselines, four discriminator thresholds, single-ended zero, differential zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| oc_i | input | 4 | Overcurrent indicators, one per supply |
| pwr_en_o | output | 4 | Effective supply enables |
| pwr_dis_o | output | 4 | Supply discharge controls |
| sw_o | output | 4 | Signal-switch controls |
| spi_sck_i | input | 1 | SPI clock from the board |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from the board |
| uart_tx_o | output | 1 | UART command line to the board |

## Verification
The control outputs change on the first clock edge after a write. A flag, and the masking of its enable, appears on the third edge after an overcurrent level is applied. A behavioural model advances on each rising edge and is compared with the outputs at every falling edge, so both latencies are checked to the exact cycle.

A UART command begins one or two cycles after its trigger. A monitor in the bench decodes each byte at the centre of each bit time and matches it against a queue of expected bytes, so the byte order and content are checked but the exact start cycle is not.

Mirror readings change three to four clocks after chip select rises. The bench reads them back only after an idle gap of several SPI bit times has passed.

// File: rtl/feb_pkg.sv
package feb_pkg;
  localparam int unsigned N_SENSOR      = 2;
  localparam int unsigned N_SUPPLY      = 2 * N_SENSOR;
  localparam int unsigned N_SW          = 2 * N_SENSOR;
  localparam int unsigned CTRL_W        = 2 * N_SUPPLY + N_SW;
  localparam int unsigned ADC_W         = 16;
  localparam int unsigned CH_PER_SENSOR = 16;
  localparam int unsigned N_CHAN        = N_SENSOR * CH_PER_SENSOR;
  localparam int unsigned CH_IDX_W      = $clog2(N_CHAN);
  localparam int unsigned ADDR_W        = 6;
  localparam int unsigned DATA_W        = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OC   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADC  = ADDR_W'(16);

  localparam logic [7:0] CMD_PWR = 8'h01;
  localparam logic [7:0] CMD_SW  = 8'h02;

  typedef struct packed {
    logic [N_SW-1:0]     sw;
    logic [N_SUPPLY-1:0] dis;
    logic [N_SUPPLY-1:0] ena;
  } ctrl_t;
endpackage

// File: rtl/feb_spi_rx.sv
module feb_spi_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sck_i,
  input  logic         cs_ni,
  input  logic         mosi_i,
  output logic         frame_start_o,
  output logic         frame_end_o,
  output logic         word_valid_o,
  output logic [W-1:0] word_o,
  output logic         partial_o
);
  localparam int unsigned BW = $clog2(W);

  logic [1:0]    sck_sy, cs_sy, mosi_sy;
  logic          sck_d, cs_d;
  logic [BW-1:0] bit_cnt_q;
  logic [W-1:0]  sh_q;
  logic          valid_q;
  logic          sck_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      cs_sy   <= {cs_sy[0], cs_ni};
      mosi_sy <= {mosi_sy[0], mosi_i};
      sck_d   <= sck_sy[1];
      cs_d    <= cs_sy[1];
    end
  end

  assign sck_rise      = sck_sy[1] & ~sck_d;
  assign frame_start_o = ~cs_sy[1] & cs_d;
  assign frame_end_o   = cs_sy[1] & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      sh_q      <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (frame_start_o) begin
        bit_cnt_q <= '0;
      end else if (!cs_sy[1] && sck_rise) begin
        sh_q <= {sh_q[W-2:0], mosi_sy[1]};
        if (bit_cnt_q == BW'(W - 1)) begin
          bit_cnt_q <= '0;
          valid_q   <= 1'b1;
        end else begin
          bit_cnt_q <= bit_cnt_q + BW'(1);
        end
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_o       = sh_q;
  assign partial_o    = (bit_cnt_q != '0);
endmodule

// File: rtl/feb_adc_mirror.sv
module feb_adc_mirror #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 16,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned CW = $clog2(N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          frame_end_i,
  input  logic          partial_i,
  input  logic          word_valid_i,
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  stage_q [N];
  logic [W-1:0]  live_q  [N];
  logic          commit;

  // counts up to N+1 so that an overlong frame is also refused
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (frame_start_i)                       cnt_q <= '0;
    else if (word_valid_i && cnt_q <= CW'(N))     cnt_q <= cnt_q + CW'(1);
  end

  assign commit = frame_end_i && (cnt_q == CW'(N)) && !partial_i;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk_i) begin
      if (word_valid_i && cnt_q == CW'(i)) stage_q[i] <= word_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     live_q[i] <= '0;
      else if (commit) live_q[i] <= stage_q[i];
    end
  end

  assign rd_data_o = live_q[rd_idx_i];
endmodule

// File: rtl/feb_uart_tx.sv
module feb_uart_tx #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT + 1);

  logic [9:0]    sh_q;
  logic [3:0]    bits_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bits_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        bits_q <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_q  <= '0;
      sh_q   <= {1'b1, sh_q[9:1]};
      bits_q <= bits_q + 4'd1;
      if (bits_q == 4'd9) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;
endmodule

// File: rtl/feb_bridge.sv
module feb_bridge
  import feb_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N_SUPPLY-1:0] oc_i,
  output logic [N_SUPPLY-1:0] pwr_en_o,
  output logic [N_SUPPLY-1:0] pwr_dis_o,
  output logic [N_SW-1:0]     sw_o,
  input  logic                spi_sck_i,
  input  logic                spi_cs_ni,
  input  logic                spi_mosi_i,
  output logic                uart_tx_o
);
  ctrl_t               ctrl_q, eff, snap_q;
  logic [N_SUPPLY-1:0] oc_s1, oc_s2, flag_q, clr;
  logic                ctrl_wr, pending_q, active_q, take, tx_start, tx_busy;
  logic [1:0]          idx_q;
  logic [7:0]          tx_byte;
  logic                wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:CTRL_W];
  assign ctrl_wr      = we_i && (addr_i == A_CTRL);
  assign clr          = (we_i && addr_i == A_OC) ? wdata_i[N_SUPPLY-1:0] : '0;

  always_comb begin
    eff     = ctrl_q;
    eff.ena = ctrl_q.ena & ~flag_q;
  end

  assign pwr_en_o  = eff.ena;
  assign pwr_dis_o = ctrl_q.dis;
  assign sw_o      = ctrl_q.sw;

  assign take     = pending_q && !active_q;
  assign tx_start = active_q && !tx_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      oc_s1     <= '0;
      oc_s2     <= '0;
      flag_q    <= '0;
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
      snap_q    <= '0;
    end else begin
      oc_s1  <= oc_i;
      oc_s2  <= oc_s1;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      // set has priority over a clear in the same cycle
      flag_q    <= (flag_q & ~clr) | oc_s2;
      pending_q <= (pending_q && !take) || ctrl_wr || (|(oc_s2 & ~flag_q));
      if (take) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        snap_q   <= eff;
      end else if (tx_start) begin
        idx_q <= idx_q + 2'd1;
        if (idx_q == 2'd3) active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (idx_q)
      2'd0:    tx_byte = CMD_PWR;
      2'd1:    tx_byte = 8'({snap_q.dis, snap_q.ena});
      2'd2:    tx_byte = CMD_SW;
      default: tx_byte = 8'(snap_q.sw);
    endcase
  end

  feb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .data_i  (tx_byte),
    .tx_o    (uart_tx_o),
    .busy_o  (tx_busy)
  );

  logic               f_start, f_end, w_valid, partial;
  logic [ADC_W-1:0]   w_data, adc_rd;
  logic [ADDR_W-1:0]  adc_off;
  logic               in_adc;

  feb_spi_rx #(.W(ADC_W)) u_spi (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sck_i         (spi_sck_i),
    .cs_ni         (spi_cs_ni),
    .mosi_i        (spi_mosi_i),
    .frame_start_o (f_start),
    .frame_end_o   (f_end),
    .word_valid_o  (w_valid),
    .word_o        (w_data),
    .partial_o     (partial)
  );

  assign adc_off = addr_i - A_ADC;
  assign in_adc  = (addr_i >= A_ADC) && (adc_off < ADDR_W'(N_CHAN));

  feb_adc_mirror #(.N(N_CHAN), .W(ADC_W)) u_mirror (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (f_start),
    .frame_end_i   (f_end),
    .partial_i     (partial),
    .word_valid_i  (w_valid),
    .word_i        (w_data),
    .rd_idx_i      (adc_off[CH_IDX_W-1:0]),
    .rd_data_o     (adc_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)    rdata_o = DATA_W'(ctrl_q);
    else if (addr_i == A_OC) rdata_o = DATA_W'(flag_q);
    else if (in_adc)         rdata_o = DATA_W'(adc_rd);
  end
endmodule

// File: rtl/feb_bridge_chk.sv
module feb_bridge_chk
  import feb_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [N_SUPPLY-1:0] pwr_dis_o,
  input logic [N_SW-1:0]     sw_o,
  input logic                uart_tx_o,
  input logic [N_SUPPLY-1:0] flag_q,
  input logic                pending_q,
  input logic                active_q,
  input logic                tx_busy
);
  logic [N_SUPPLY-1:0] clr_m;
  logic                chk_unused;

  assign chk_unused = ^wdata_i[DATA_W-1:CTRL_W];
  assign clr_m      = (we_i && addr_i == A_OC) ? wdata_i[N_SUPPLY-1:0] : '0;

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=>
      (pwr_dis_o == $past(wdata_i[2*N_SUPPLY-1:N_SUPPLY]) &&
       sw_o == $past(wdata_i[CTRL_W-1:2*N_SUPPLY]))); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_q & ~clr_m)) |=> (($past(flag_q & ~clr_m) & ~flag_q) == '0)); // R4

  AST_TX_QUEUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=> (pending_q || active_q)); // R5

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !uart_tx_o); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i > A_OC && addr_i < A_ADC) || addr_i >= ADDR_W'(A_ADC + N_CHAN)) |->
      rdata_o == '0); // R9
endmodule

bind feb_bridge feb_bridge_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pwr_dis_o (pwr_dis_o),
  .sw_o      (sw_o),
  .uart_tx_o (uart_tx_o),
  .flag_q    (flag_q),
  .pending_q (pending_q),
  .active_q  (active_q),
  .tx_busy   (tx_busy)
);

// File: tb/feb_bridge_tb.sv
module feb_bridge_tb;
  localparam int CPB      = 8;
  localparam int SPI_HALF = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  oc_i = '0;
  logic [3:0]  pwr_en_o, pwr_dis_o, sw_o;
  logic        spi_sck_i = 1'b0, spi_cs_ni = 1'b1, spi_mosi_i = 1'b0;
  logic        uart_tx_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  feb_bridge #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .oc_i,
    .pwr_en_o, .pwr_dis_o, .sw_o, .spi_sck_i, .spi_cs_ni, .spi_mosi_i, .uart_tx_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [11:0] m_ctrl = '0;
  logic [3:0]  m_flag = '0;
  logic [3:0]  oc_hist[$];
  logic [7:0]  exp_q[$];
  logic [15:0] exp_adc[32];
  logic [3:0]  m_old, m_clr, m_nflag;

  task automatic push_cmd(input logic [11:0] c, input logic [3:0] f);
    exp_q.push_back(8'h01);
    exp_q.push_back({c[7:4], c[3:0] & ~f});
    exp_q.push_back(8'h02);
    exp_q.push_back({4'h0, c[11:8]});
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      oc_hist.delete();
      m_flag = '0;
      m_ctrl = '0;
    end else begin
      m_old = (oc_hist.size() == 2) ? oc_hist.pop_front() : 4'h0;
      oc_hist.push_back(oc_i);
      m_clr   = (we_i && addr_i == 6'd1) ? wdata_i[3:0] : 4'h0;
      m_nflag = (m_flag & ~m_clr) | m_old;
      if (we_i && addr_i == 6'd0) begin
        m_ctrl = wdata_i[11:0];
        push_cmd(m_ctrl, m_nflag);
      end else if ((m_nflag & ~m_flag) != 4'h0) begin
        push_cmd(m_ctrl, m_nflag);
      end
      m_flag = m_nflag;
    end
  end

  // every-clock comparison of the control outputs
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("R2 pwr_en_o", 32'(pwr_en_o), 32'(m_ctrl[3:0] & ~m_flag));
      check("R1 pwr_dis_o", 32'(pwr_dis_o), 32'(m_ctrl[7:4]));
      check("R1 sw_o", 32'(sw_o), 32'(m_ctrl[11:8]));
    end
  end

  // ---------------- UART monitor ----------------
  logic [7:0] mon_b;
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && uart_tx_o === 1'b0) begin
        repeat (CPB / 2) @(negedge clk_i);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk_i);
          mon_b[i] = uart_tx_o;
        end
        repeat (CPB) @(negedge clk_i);
        check("R6 stop bit", 32'(uart_tx_o), 32'd1);
        if (exp_q.size() == 0) check("R5 unexpected uart byte", 32'(mon_b), 32'hFFFF);
        else                   check("R5 uart byte", 32'(mon_b), 32'(exp_q.pop_front()));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic bus_rd(input string req, input logic [5:0] a, input logic [15:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(req, 32'(rdata_o), 32'(exp));
  endtask

  function automatic logic [15:0] word_of(input int seed, input int w);
    return 16'((seed * 40503 + w * 2579 + 17) & 32'hFFFF);
  endfunction

  task automatic send_bit(input logic b);
    spi_mosi_i = b;
    repeat (SPI_HALF) @(negedge clk_i);
    spi_sck_i = 1'b1;
    repeat (SPI_HALF) @(negedge clk_i);
    spi_sck_i = 1'b0;
  endtask

  task automatic spi_frame(input int nw, input int extra, input int seed);
    spi_cs_ni = 1'b0;
    repeat (SPI_HALF) @(negedge clk_i);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] v;
      v = word_of(seed, w);
      for (int b = 15; b >= 0; b--) send_bit(v[b]);
    end
    for (int b = 0; b < extra; b++) send_bit(1'b1);
    repeat (SPI_HALF) @(negedge clk_i);
    spi_cs_ni = 1'b1;
    repeat (4 * SPI_HALF) @(negedge clk_i);
  endtask

  task automatic check_mirror(input string req);
    for (int i = 0; i < 32; i++) bus_rd(req, 6'(16 + i), exp_adc[i]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < 32; i++) exp_adc[i] = '0;
    repeat (5) @(negedge clk_i);
    check("R1 reset pwr_en_o", 32'(pwr_en_o), 0);
    check("R6 reset uart idle", 32'(uart_tx_o), 1);
    rst_ni = 1'b1;
    bus_rd("R1 reset ctrl", 6'd0, 16'h0);
    bus_rd("R3 reset flags", 6'd1, 16'h0);
    bus_rd("R7 reset reading", 6'd16, 16'h0);

    // R1/R5: control patterns
    bus_wr(6'd0, 16'h05A3);
    repeat (400) @(negedge clk_i);
    bus_rd("R1 readback", 6'd0, 16'h05A3);
    bus_wr(6'd0, 16'hFFFF);
    repeat (400) @(negedge clk_i);
    bus_rd("R1 readback upper ignored", 6'd0, 16'h0FFF);

    // R3: synchronizer latency on supply 1
    @(negedge clk_i); oc_i = 4'b0010;
    @(negedge clk_i); check("R3 no flag after 1 edge", 32'(pwr_en_o), 32'hF);
    @(negedge clk_i); check("R3 no flag after 2 edges", 32'(pwr_en_o), 32'hF);
    @(negedge clk_i); check("R3 flag masks enable on edge 3", 32'(pwr_en_o), 32'hD);
    oc_i = 4'b0000;
    repeat (400) @(negedge clk_i);
    bus_rd("R3 flag readback", 6'd1, 16'h0002);

    // R2/R5: write while flagged sends masked enables
    bus_wr(6'd0, 16'h03C7);
    repeat (400) @(negedge clk_i);
    check("R2 masked enable", 32'(pwr_en_o), 32'h5);

    // R4: set wins over clear while input held
    @(negedge clk_i); oc_i = 4'b1000;
    repeat (400) @(negedge clk_i);
    bus_wr(6'd1, 16'h0008);
    bus_rd("R4 set wins over clear", 6'd1, 16'h000A);
    oc_i = 4'b0000;
    repeat (5) @(negedge clk_i);
    bus_wr(6'd1, 16'h0000);
    bus_rd("R4 zero write no effect", 6'd1, 16'h000A);
    bus_wr(6'd1, 16'h0002);
    bus_rd("R4 clear one flag", 6'd1, 16'h0008);
    bus_wr(6'd1, 16'h0008);
    bus_rd("R4 clear last flag", 6'd1, 16'h0000);
    check("R2 enables restored", 32'(pwr_en_o), 32'h7);

    // R9: unmapped addresses
    bus_wr(6'd5, 16'hFFFF);
    bus_wr(6'd50, 16'h1234);
    bus_rd("R9 unmapped 5", 6'd5, 16'h0);
    bus_rd("R9 unmapped 15", 6'd15, 16'h0);
    bus_rd("R9 unmapped 48", 6'd48, 16'h0);
    bus_rd("R9 unmapped 63", 6'd63, 16'h0);
    bus_rd("R9 ctrl untouched", 6'd0, 16'h03C7);

    // R7/R10: full frame
    spi_frame(32, 0, 3);
    for (int i = 0; i < 32; i++) exp_adc[i] = word_of(3, i);
    bus_rd("R10 sensor0 first channel at 16", 6'd16, word_of(3, 0));
    bus_rd("R10 sensor1 first channel at 32", 6'd32, word_of(3, 16));
    bus_rd("R10 last channel at 47", 6'd47, word_of(3, 31));
    check_mirror("R7 full frame reading");

    // R8: short frame and partial frame discarded
    spi_frame(20, 0, 9);
    check_mirror("R8 short frame discarded");
    spi_frame(32, 5, 11);
    check_mirror("R8 partial bits discarded");

    // R7: second full frame replaces all
    spi_frame(32, 0, 21);
    for (int i = 0; i < 32; i++) exp_adc[i] = word_of(21, i);
    check_mirror("R7 refreshed reading");

    repeat (500) @(negedge clk_i);
    check("R5 all expected bytes sent", 32'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule